// File: doc/BRIEF.md
# PCI Master DMA Burst Sequencer

This block sits on the local side of a 32-bit PCI master core and runs one DMA burst per job. A job is offered on a valid/ready descriptor port. The descriptor carries a 4-bit PCI bus command, a start byte address, a word count, a byte-enable mode bit and a fixed active-low byte-enable value. The block checks the job first. It rejects unknown command codes, start addresses that are not on a 4-byte boundary, and a zero word count. A rejected job raises a one-cycle error pulse and never requests the bus.

An accepted job raises the bus request toward the core and holds the command steady until the request falls. The block keeps two running addresses, one for DMA writes and one for DMA reads. Only the address that matches the job's direction is loaded with the start address, and it advances by 4 on every transfer the core reports. Entries from a local write FIFO (data and byte enables) flow to the core over a valid/ready stream that the core acknowledges. For a write job every word moves through this stream. For a read job only the byte enables move, and only when per-word byte enables are selected. In fixed mode the single descriptor byte-enable value is driven for the whole burst.

A down-counter loaded with the word count tracks completion. The request stays high through the clock after the final transfer and falls on the second clock. In that same cycle a one-cycle done pulse is raised and the block returns to idle.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, core_req, job_done, job_err and core_data_valid are 0, job_ready is 1, and both running addresses are 0.
- R2: Command codes 0000, 0010, 0110, 1010, 1100 and 1110 are reads. Codes 0001, 0011, 0111, 1011 and 1111 are writes. Any other code offered when job_ready is 1 gives job_err=1 in the next cycle only, and core_req stays 0.
- R3: A job whose job_addr[1:0] is not 00, or whose word count is 0, is rejected in the same way as in R2: job_err pulses for one cycle and core_req stays 0.
- R4: A valid job raises core_req in the cycle after acceptance. core_cmd equals the job's command and does not change while core_req is 1.
- R5: For a job of N words, core_req stays 1 in the cycle after the N-th core_xfer cycle and is 0 in the cycle after that. job_done is 1 in exactly that second cycle.
- R6: job_ready is 1 only while idle. A descriptor offered while a job runs is ignored: it changes neither core_cmd nor either address.
- R7: For a write job, core_wr_addr equals the start address from the cycle after acceptance and grows by 4 after each transfer. core_rd_addr does not change.
- R8: For a read job, core_rd_addr equals the start address from the cycle after acceptance and grows by 4 after each transfer. core_wr_addr does not change.
- R9: With job_be_sel=0, core_be_n equals the descriptor's job_be_n in every cycle of the burst. A read job in this mode never asserts core_data_valid.
- R10: With job_be_sel=1, core_be_n follows wr_be_n. On a write job, core_data follows wr_data. core_be_sel reflects the job's mode.
- R11: While the job still has entries to move, core_data_valid follows wr_valid, and wr_ready = core_data_valid and core_data_ack. An entry held with core_data_ack=0 stays offered and is not popped. After N pops, and outside a job, core_data_valid and wr_ready are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Descriptor offered |
| job_ready | output | 1 | Block idle, descriptor taken |
| job_cmd | input | 4 | PCI bus command |
| job_addr | input | 32 | Start byte address |
| job_words | input | 8 | Number of 32-bit words |
| job_be_sel | input | 1 | 0: fixed byte enables, 1: per-word byte enables |
| job_be_n | input | 4 | Fixed active-low byte enables |
| job_done | output | 1 | One-cycle completion pulse |
| job_err | output | 1 | One-cycle rejection pulse |
| wr_valid | input | 1 | Local FIFO entry present |
| wr_ready | output | 1 | Local FIFO pop |
| wr_data | input | 32 | Local FIFO write data |
| wr_be_n | input | 4 | Local FIFO active-low byte enables |
| core_req | output | 1 | Bus request to the core |
| core_cmd | output | 4 | Command held for the burst |
| core_wr_addr | output | 32 | Running DMA write address |
| core_rd_addr | output | 32 | Running DMA read address |
| core_data_valid | output | 1 | Entry offered to the core |
| core_data_ack | input | 1 | Core accepts the offered entry |
| core_data | output | 32 | Data offered to the core |
| core_be_n | output | 4 | Active-low byte enables to the core |
| core_be_sel | output | 1 | Byte-enable mode of the running job |
| core_xfer | input | 1 | One data phase completed on the bus |

## Verification
Each result has a fixed cycle. Acceptance, rejection and address loading show one clock after the descriptor edge. Each address step shows one clock after its transfer edge. The request falls and the done pulse rises two clocks after the final transfer. The stream outputs (core_data_valid, wr_ready, core_data and core_be_n) are combinational, so they are due in the same cycle as their inputs. The bench drives inputs at the falling edge and samples one nanosecond later, which is after the registered values of the last rising edge have settled. It sweeps every command code, alignment offset, several word counts, both directions, both byte-enable modes and stalled handshakes, and computes the expected values arithmetically.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_t;

  // Command code is recognised at all.
  function automatic logic cmd_known(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0110, 4'b0111,
      4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111: cmd_known = 1'b1;
      default:                                      cmd_known = 1'b0;
    endcase
  endfunction

  // Command moves data toward the bus.
  function automatic logic cmd_writes(input logic [3:0] c);
    case (c)
      4'b0001, 4'b0011, 4'b0111, 4'b1011, 4'b1111: cmd_writes = 1'b1;
      default:                                      cmd_writes = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_job_check.sv
module dma_job_check
  import dma_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int ALIGN_BITS = 2
) (
  input  logic [3:0]            cmd,
  input  logic [ALIGN_BITS-1:0] addr_lsb,
  input  logic [CNT_W-1:0]      words,
  output logic                  ok,
  output logic                  is_write
);

  logic aligned;
  logic nonzero;

  always_comb begin
    aligned  = (addr_lsb == '0);
    nonzero  = (words != '0);
    ok       = cmd_known(cmd) && aligned && nonzero;
    is_write = cmd_writes(cmd);
  end

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] words,
  input  logic             xfer,
  output logic             idle,
  output logic             active,
  output logic             xfer_hit,
  output logic             done
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] left_q;
  logic             done_q;
  logic             last_hit;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    active   = (state_q == ST_RUN) || (state_q == ST_TAIL);
    xfer_hit = (state_q == ST_RUN) && xfer;
    last_hit = xfer_hit && (left_q == CNT_W'(1));
    done     = done_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            left_q  <= words;
          end
        end
        ST_RUN: begin
          if (xfer_hit) left_q <= left_q - CNT_W'(1);
          if (last_hit) state_q <= ST_TAIL;
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  release_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |=> (state_q == ST_IDLE) && done_q);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              active,
  input  logic              advance,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);

  localparam int NCH = 2;

  logic              dir_wr_q;
  logic [ADDR_W-1:0] addr_q [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n)    dir_wr_q <= 1'b0;
    else if (load) dir_wr_q <= load_wr;
  end

  // channel 0 follows write jobs, channel 1 follows read jobs
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic load_me;
    logic run_me;
    assign load_me = load && ((ch == 0) ? load_wr : !load_wr);
    assign run_me  = advance && ((ch == 0) ? dir_wr_q : !dir_wr_q);

    always_ff @(posedge clk) begin
      if (!rst_n)       addr_q[ch] <= '0;
      else if (load_me) addr_q[ch] <= start_addr;
      else if (run_me)  addr_q[ch] <= addr_q[ch] + ADDR_W'(STEP);
    end
  end

  assign wr_addr = addr_q[0];
  assign rd_addr = addr_q[1];

  // R7
  wr_job_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dir_wr_q) |=> $stable(rd_addr));

  // R8
  rd_job_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dir_wr_q) |=> $stable(wr_addr));

endmodule

// File: rtl/dma_be_stream.sv
module dma_be_stream #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  words,
  input  logic              load_stream,
  input  logic              load_be_sel,
  input  logic [BE_W-1:0]   load_be_n,
  input  logic              active,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be_n,
  input  logic              core_data_ack,
  output logic              wr_ready,
  output logic              core_data_valid,
  output logic [DATA_W-1:0] core_data,
  output logic [BE_W-1:0]   core_be_n,
  output logic              core_be_sel
);

  logic [CNT_W-1:0] left_q;
  logic             be_sel_q;
  logic [BE_W-1:0]  be_fixed_q;
  logic             pop;

  always_comb begin
    core_data_valid = active && (left_q != '0) && wr_valid;
    pop             = core_data_valid && core_data_ack;
    wr_ready        = pop;
    core_data       = wr_data;
    core_be_n       = be_sel_q ? wr_be_n : be_fixed_q;
    core_be_sel     = be_sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q     <= '0;
      be_sel_q   <= 1'b0;
      be_fixed_q <= '1;
    end else if (load) begin
      left_q     <= load_stream ? words : '0;
      be_sel_q   <= load_be_sel;
      be_fixed_q <= load_be_n;
    end else if (pop) begin
      left_q     <= left_q - CNT_W'(1);
    end
  end

  // R11
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> !wr_ready && !core_data_valid);

  // R9
  fixed_be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !be_sel_q) |-> $stable(core_be_n));

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int BE_W       = DATA_W / 8,
  localparam int ALIGN_BITS = $clog2(BE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [3:0]        job_cmd,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [CNT_W-1:0]  job_words,
  input  logic              job_be_sel,
  input  logic [BE_W-1:0]   job_be_n,
  output logic              job_done,
  output logic              job_err,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be_n,
  output logic              core_req,
  output logic [3:0]        core_cmd,
  output logic [ADDR_W-1:0] core_wr_addr,
  output logic [ADDR_W-1:0] core_rd_addr,
  output logic              core_data_valid,
  input  logic              core_data_ack,
  output logic [DATA_W-1:0] core_data,
  output logic [BE_W-1:0]   core_be_n,
  output logic              core_be_sel,
  input  logic              core_xfer
);

  logic       job_ok;
  logic       job_is_wr;
  logic       idle;
  logic       active;
  logic       xfer_hit;
  logic       accept;
  logic       start;
  logic       err_q;
  logic [3:0] cmd_q;

  dma_job_check #(.CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS)) i_check (
    .cmd      (job_cmd),
    .addr_lsb (job_addr[ALIGN_BITS-1:0]),
    .words    (job_words),
    .ok       (job_ok),
    .is_write (job_is_wr)
  );

  assign job_ready = idle;
  assign accept    = job_valid && idle;
  assign start     = accept && job_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      err_q <= accept && !job_ok;
      if (start) cmd_q <= job_cmd;
    end
  end

  dma_xfer_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .words    (job_words),
    .xfer     (core_xfer),
    .idle     (idle),
    .active   (active),
    .xfer_hit (xfer_hit),
    .done     (job_done)
  );

  dma_addr_track #(.ADDR_W(ADDR_W), .STEP(BE_W)) i_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_wr    (job_is_wr),
    .start_addr (job_addr),
    .active     (active),
    .advance    (xfer_hit),
    .wr_addr    (core_wr_addr),
    .rd_addr    (core_rd_addr)
  );

  dma_be_stream #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_stream (
    .clk             (clk),
    .rst_n           (rst_n),
    .load            (start),
    .words           (job_words),
    .load_stream     (job_is_wr || job_be_sel),
    .load_be_sel     (job_be_sel),
    .load_be_n       (job_be_n),
    .active          (active),
    .wr_valid        (wr_valid),
    .wr_data         (wr_data),
    .wr_be_n         (wr_be_n),
    .core_data_ack   (core_data_ack),
    .wr_ready        (wr_ready),
    .core_data_valid (core_data_valid),
    .core_data       (core_data),
    .core_be_n       (core_be_n),
    .core_be_sel     (core_be_sel)
  );

  assign core_req = active;
  assign core_cmd = cmd_q;
  assign job_err  = err_q;

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && $past(core_req)) |-> $stable(core_cmd));

  // R3
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_err |-> !core_req);

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> !job_ready);

endmodule

// File: tb/test_dma_burst_seq.sv
`timescale 1ns/1ps
module test_dma_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic [3:0]  job_cmd = '0;
  logic [31:0] job_addr = '0;
  logic [7:0]  job_words = '0;
  logic        job_be_sel = 1'b0;
  logic [3:0]  job_be_n = '1;
  logic        job_done;
  logic        job_err;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be_n = '1;
  logic        core_req;
  logic [3:0]  core_cmd;
  logic [31:0] core_wr_addr;
  logic [31:0] core_rd_addr;
  logic        core_data_valid;
  logic        core_data_ack = 1'b0;
  logic [31:0] core_data;
  logic [3:0]  core_be_n;
  logic        core_be_sel;
  logic        core_xfer = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_wr = '0;
  logic [31:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  dma_burst_seq i_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_cmd(job_cmd), .job_addr(job_addr), .job_words(job_words),
    .job_be_sel(job_be_sel), .job_be_n(job_be_n), .job_done(job_done),
    .job_err(job_err), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .core_req(core_req),
    .core_cmd(core_cmd), .core_wr_addr(core_wr_addr),
    .core_rd_addr(core_rd_addr), .core_data_valid(core_data_valid),
    .core_data_ack(core_data_ack), .core_data(core_data),
    .core_be_n(core_be_n), .core_be_sel(core_be_sel), .core_xfer(core_xfer)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit is_known(input logic [3:0] c);
    return c inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
  endfunction

  function automatic bit is_wr(input logic [3:0] c);
    return c inside {4'h1, 4'h3, 4'h7, 4'hB, 4'hF};
  endfunction

  // rejected descriptor (R2, R3)
  task automatic offer_bad(input logic [3:0] c, input logic [31:0] a, input logic [7:0] n,
                           input string req);
    job_cmd = c; job_addr = a; job_words = n; job_valid = 1'b1;
    step();
    job_valid = 1'b0;
    #1;
    chk({req, " err pulse"}, job_err, 1);
    chk({req, " no request"}, core_req, 0);
    step();
    #1;
    chk({req, " err ends"}, job_err, 0);
    chk({req, " still idle"}, job_ready, 1);
    chk({req, " wr addr kept"}, core_wr_addr, exp_wr);
    chk({req, " rd addr kept"}, core_rd_addr, exp_rd);
  endtask

  task automatic run_job(input logic [3:0] c, input logic [31:0] a, input int n,
                         input logic sel, input logic [3:0] fbe);
    bit wr = is_wr(c);
    bit strm = wr || sel;
    job_cmd = c; job_addr = a; job_words = 8'(n); job_be_sel = sel; job_be_n = fbe;
    job_valid = 1'b1;
    #1 chk("R6 ready idle", job_ready, 1);
    step();
    job_valid = 1'b0;
    if (wr) exp_wr = a; else exp_rd = a;
    #1;
    chk("R4 req up", core_req, 1);
    chk("R4 cmd", core_cmd, c);
    chk("R10 be_sel out", core_be_sel, sel);
    chk("R7 wr addr load", core_wr_addr, exp_wr);
    chk("R8 rd addr load", core_rd_addr, exp_rd);
    for (int i = 0; i < n; i++) begin
      logic [31:0] pat = 32'hA500_0000 ^ (a << 4) ^ 32'(i * 32'h0101);
      logic [3:0]  pbe = 4'(i + 5);
      if (i == 0) begin
        // R6: busy offer must be ignored
        job_valid = 1'b1; job_cmd = 4'h3; job_addr = 32'h0000_0F00; job_words = 8'd9;
      end
      wr_valid = 1'b1; wr_data = pat; wr_be_n = pbe;
      if (i % 2 == 1) begin
        core_data_ack = 1'b0; core_xfer = 1'b0;
        #1;
        chk("R11 stalled valid", core_data_valid, strm);
        chk("R11 stalled no pop", wr_ready, 0);
        step();
      end
      core_data_ack = 1'b1; core_xfer = 1'b1;
      #1;
      chk("R6 busy not ready", job_ready, 0);
      chk("R11 valid", core_data_valid, strm);
      chk("R11 pop", wr_ready, strm);
      chk(sel ? "R10 be stream" : "R9 be fixed", core_be_n, sel ? pbe : fbe);
      if (wr) chk("R10 data", core_data, pat);
      step();
      job_valid = 1'b0;
      core_xfer = 1'b0; core_data_ack = 1'b0; wr_valid = 1'b0;
      if (wr) exp_wr = exp_wr + 4; else exp_rd = exp_rd + 4;
      #1;
      chk("R7 wr addr", core_wr_addr, exp_wr);
      chk("R8 rd addr", core_rd_addr, exp_rd);
      chk("R4 cmd stable", core_cmd, c);
      chk("R5 req held", core_req, 1);
      chk("R5 no early done", job_done, 0);
    end
    // tail cycle: no entries left to move
    wr_valid = 1'b1; core_data_ack = 1'b1;
    #1;
    chk("R11 none after N", core_data_valid, 0);
    chk("R11 no pop after N", wr_ready, 0);
    step();
    #1;
    chk("R5 req dropped", core_req, 0);
    chk("R5 done pulse", job_done, 1);
    chk("R6 ready again", job_ready, 1);
    chk("R11 idle no pop", wr_ready, 0);
    wr_valid = 1'b0; core_data_ack = 1'b0;
    step();
    #1;
    chk("R5 done one cycle", job_done, 0);
    chk("R7 wr addr final", core_wr_addr, exp_wr);
    chk("R8 rd addr final", core_rd_addr, exp_rd);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 req", core_req, 0);
    chk("R1 ready", job_ready, 1);
    chk("R1 done", job_done, 0);
    chk("R1 err", job_err, 0);
    chk("R1 valid", core_data_valid, 0);
    chk("R1 wr addr", core_wr_addr, 0);
    chk("R1 rd addr", core_rd_addr, 0);
    step();

    // every command code
    for (int c = 0; c < 16; c++) begin
      if (is_known(4'(c)))
        run_job(4'(c), 32'h1000 + 32'(c * 64), 1 + (c % 3), c[0], 4'(~c));
      else
        offer_bad(4'(c), 32'h2000, 8'd2, "R2");
    end

    // misaligned and empty jobs
    for (int off = 1; off < 4; off++) begin
      offer_bad(4'h7, 32'h3000 + 32'(off), 8'd2, "R3");
      offer_bad(4'h6, 32'h3000 + 32'(off), 8'd2, "R3");
    end
    offer_bad(4'h7, 32'h3100, 8'd0, "R3");

    // word count x direction x byte-enable mode
    for (int n = 1; n <= 5; n++)
      for (int s = 0; s < 2; s++) begin
        run_job(4'h7, 32'h8000 + 32'(n * 256), n, s[0], 4'h3);
        run_job(4'hC, 32'hC000 + 32'(n * 256), n, s[0], 4'h9);
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule